// File: doc/BRIEF.md
# Drift-Compensating Elastic Sample Buffer

This block joins a link-side producer to an audio-side consumer whose sample clocks are nominally equal but drift slightly apart. Whole packets of samples arrive on a valid/ready input and are kept in a small ring of packet slots. On every local sample tick the block emits one sample, and it groups these outputs into frames of fixed length. Both sides share one clock. Rate mismatch is modelled by how often packets and ticks arrive.

At the first tick of each frame the block compares how many slots are held against a target midpoint. If too few slots are held, the block repeats the previous output sample and takes nothing from the buffer. If too many slots are held, it skips one buffered sample and outputs the one after it. Either way, the occupancy is steered back toward the target, which in effect trims the local sample rate by one sample per frame at most. Overflow, underflow, corrections and occupancy are brought out as status for checking. After reset, output stays silent until the buffer first reaches the target.

Top module: `elastic_drift_buffer`

## Requirements
- R1: The buffer holds SLOTS packets (default 4). `occupancy` reports the number of held packets, from 0 to SLOTS. `pkt_ready` is high exactly when occupancy is below SLOTS. A packet is stored when `pkt_valid` is high while `pkt_ready` is high.
- R2: A packet offered while the buffer is full is dropped and leaves the stored data unchanged. In the next cycle `ovf_pulse` is high for one cycle and `ovf_count` has risen by one.
- R3: At a frame-start tick with occupancy below TARGET (default 2), the output repeats the previous output sample, no buffered sample is used, and `ins_count` rises by one.
- R4: At a frame-start tick with occupancy above TARGET, one buffered sample is discarded and the sample after it is output, and `del_count` rises by one.
- R5: Corrections happen only at frame-start ticks, so a frame has at most one. `fix_mode` is loaded at each frame start and then held for the rest of the frame. Its codes are 0 for no correction, 1 for repeat and 2 for skip.
- R6: A frame spans FRAME_LEN ticks (default 128). `out_frame_start` is high together with the first `out_valid` of each frame.
- R7: An uncorrected tick outputs the next buffered sample in arrival order. Sample j of a packet sits in bits [j*SAMPLE_W +: SAMPLE_W], starting from sample 0. A slot is released once its last sample has been used.
- R8: From reset until the registered occupancy first reaches TARGET, the block is muted. While muted, `muted` is high and ticks output sample 0 with no frame start. Frame counting begins at the first tick after muting ends.
- R9: An uncorrected tick while the buffer is empty and unmuted outputs 0. In the next cycle `unf_pulse` is high and `unf_count` has risen by one, and the frame position still advances.
- R10: All sample outputs are registered. `out_valid` is high in the cycle after each `sample_tick` and low otherwise.
- R11: After reset, occupancy is 0, all counts are 0, `muted` is 1, and `out_valid` and both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid | input | 1 | A packet is offered |
| pkt_ready | output | 1 | A free slot exists |
| pkt_data | input | SAMPLE_W*PKT_SAMPLES | Packet samples, sample 0 in the low bits |
| sample_tick | input | 1 | Local sample-rate strobe |
| out_valid | output | 1 | An output sample is present |
| out_sample | output | SAMPLE_W | Output sample |
| out_frame_start | output | 1 | First sample of a frame |
| fix_mode | output | 2 | Correction chosen for the current frame |
| muted | output | 1 | Start-up silence is active |
| occupancy | output | clog2(SLOTS+1) | Held packets |
| ovf_pulse | output | 1 | Packet dropped on the previous cycle |
| unf_pulse | output | 1 | Empty read on the previous cycle |
| ins_count | output | CNT_W | Repeated samples |
| del_count | output | CNT_W | Skipped samples |
| ovf_count | output | CNT_W | Dropped packets |
| unf_count | output | CNT_W | Empty reads |

## Verification
The bench builds the block with 4-sample packets, four slots, a target of two and FRAME_LEN set to 8, so a frame-start decision comes every eight ticks rather than every 128. With these values, runs where the producer is slightly fast, balanced or slightly slow each reach repeat and skip corrections within a few hundred cycles. Skips that cross a packet boundary are reached in the same runs. Short bursts with no ticks drive the buffer to full, and a starved run drains it to empty, so both overflow and underflow are exercised.

// File: rtl/esb_pkg.sv
package esb_pkg;

  // Correction applied in one frame; values are visible on the fix_mode port.
  typedef enum logic [1:0] {
    FIX_NONE   = 2'd0,
    FIX_REPEAT = 2'd1,
    FIX_SKIP   = 2'd2
  } fix_t;

  // Frame-start decision from the held packet count.
  function automatic fix_t choose_fix(input int held, input int target);
    if (held < target) return FIX_REPEAT;
    if (held > target) return FIX_SKIP;
    return FIX_NONE;
  endfunction

  // Number of buffered samples one playing tick uses up.
  function automatic int samples_used(input fix_t f, input bit empty);
    case (f)
      FIX_REPEAT: return 0;
      FIX_SKIP:   return 2;
      default:    return empty ? 0 : 1;
    endcase
  endfunction

endpackage

// File: rtl/esb_slot_ring.sv
module esb_slot_ring #(
  parameter int SLOTS = 4,
  parameter int PKT_W = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [PKT_W-1:0]             push_data,
  input  logic                         pop,
  output logic [$clog2(SLOTS+1)-1:0]   held,
  output logic [PKT_W-1:0]             head_pkt,
  output logic [PKT_W-1:0]             next_pkt
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int OCC_W = $clog2(SLOTS + 1);

  logic [PKT_W-1:0] store [SLOTS];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_nx;
  logic [OCC_W-1:0] held_q;

  function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_nx    = ring_inc(rd_ptr);
  assign head_pkt = store[rd_ptr];
  assign next_pkt = store[rd_nx];
  assign held     = held_q;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      held_q <= '0;
    end else begin
      if (push) wr_ptr <= ring_inc(wr_ptr);
      if (pop)  rd_ptr <= rd_nx;
      case ({push, pop})
        2'b10:   held_q <= held_q + 1'b1;
        2'b01:   held_q <= held_q - 1'b1;
        default: held_q <= held_q;
      endcase
    end
  end

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (rst)
    held_q <= OCC_W'(SLOTS));
  assert_push_room_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> held_q < OCC_W'(SLOTS));
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> held_q != '0);

endmodule

// File: rtl/esb_playout.sv
module esb_playout
  import esb_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int PKT_SAMPLES = 4,
  parameter int FRAME_LEN   = 128,
  parameter int TARGET      = 2,
  parameter int OCC_W       = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick,
  input  logic [OCC_W-1:0]                held,
  input  logic [SAMPLE_W*PKT_SAMPLES-1:0] head_pkt,
  input  logic [SAMPLE_W*PKT_SAMPLES-1:0] next_pkt,
  output logic                            pop,
  output logic                            out_valid,
  output logic [SAMPLE_W-1:0]             out_sample,
  output logic                            out_fs,
  output logic [1:0]                      fix_mode,
  output logic                            muted,
  output logic                            ins_evt,
  output logic                            del_evt,
  output logic                            unf_evt
);
  localparam int IDX_W = $clog2(PKT_SAMPLES);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam int PKT_W = SAMPLE_W * PKT_SAMPLES;

  logic             muted_q;
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  fix_t             fix_q, fix_now;
  logic             play, at_start, empty;
  logic [IDX_W:0]   sel_lin, end_lin;
  logic [PKT_W-1:0] src_pkt;
  logic [SAMPLE_W-1:0] picked;
  int               used;

  assign play     = tick && !muted_q;
  assign at_start = play && (pos_q == '0);
  assign empty    = (held == '0);

  always_comb begin
    fix_now = at_start ? choose_fix(int'(held), TARGET) : FIX_NONE;
    used    = samples_used(fix_now, empty);
    sel_lin = {1'b0, idx_q} + ((fix_now == FIX_SKIP) ? (IDX_W+1)'(1) : '0);
    end_lin = {1'b0, idx_q} + (IDX_W+1)'(used);
    src_pkt = sel_lin[IDX_W] ? next_pkt : head_pkt;
    picked  = src_pkt[int'(sel_lin[IDX_W-1:0])*SAMPLE_W +: SAMPLE_W];
  end

  assign pop     = play && end_lin[IDX_W];
  assign ins_evt = play && (fix_now == FIX_REPEAT);
  assign del_evt = play && (fix_now == FIX_SKIP);
  assign unf_evt = play && (fix_now == FIX_NONE) && empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      muted_q    <= 1'b1;
      pos_q      <= '0;
      idx_q      <= '0;
      fix_q      <= FIX_NONE;
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_fs     <= 1'b0;
    end else begin
      out_valid <= tick;
      out_fs    <= at_start;
      if (muted_q && held >= OCC_W'(TARGET)) muted_q <= 1'b0;
      if (tick && muted_q) out_sample <= '0;
      if (play) begin
        pos_q <= (pos_q == POS_W'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
        idx_q <= end_lin[IDX_W-1:0];
        if (at_start) fix_q <= fix_now;
        if (unf_evt) out_sample <= '0;
        else if (!ins_evt) out_sample <= picked;
      end
    end
  end

  assign fix_mode = fix_q;
  assign muted    = muted_q;

  // Checker state: playing ticks since the last correction.
  logic [POS_W:0] gap_q;
  logic           seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ins_evt || del_evt) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (play && gap_q != (POS_W+1)'(FRAME_LEN)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_one_fix_per_frame_R5: assert property (@(posedge clk) disable iff (rst)
    ((ins_evt || del_evt) && seen_q) |-> gap_q >= (POS_W+1)'(FRAME_LEN - 1));
  assert_repeat_holds_R3: assert property (@(posedge clk) disable iff (rst)
    ins_evt |=> out_sample == $past(out_sample));
  assert_skip_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    del_evt |-> held >= OCC_W'(2));
  assert_muted_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && muted_q) |=> (out_sample == '0 && !out_fs));
  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> out_sample == '0);
  assert_valid_follows_tick_R10: assert property (@(posedge clk) disable iff (rst)
    tick |=> out_valid);

endmodule

// File: rtl/esb_evt_count.sv
module esb_evt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/elastic_drift_buffer.sv
module elastic_drift_buffer #(
  parameter int SAMPLE_W    = 16,
  parameter int PKT_SAMPLES = 4,
  parameter int SLOTS       = 4,
  parameter int TARGET      = 2,
  parameter int FRAME_LEN   = 128,
  parameter int CNT_W       = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            pkt_valid,
  output logic                            pkt_ready,
  input  logic [SAMPLE_W*PKT_SAMPLES-1:0] pkt_data,
  input  logic                            sample_tick,
  output logic                            out_valid,
  output logic [SAMPLE_W-1:0]             out_sample,
  output logic                            out_frame_start,
  output logic [1:0]                      fix_mode,
  output logic                            muted,
  output logic [$clog2(SLOTS+1)-1:0]      occupancy,
  output logic                            ovf_pulse,
  output logic                            unf_pulse,
  output logic [CNT_W-1:0]                ins_count,
  output logic [CNT_W-1:0]                del_count,
  output logic [CNT_W-1:0]                ovf_count,
  output logic [CNT_W-1:0]                unf_count
);
  localparam int PKT_W  = SAMPLE_W * PKT_SAMPLES;
  localparam int OCC_W  = $clog2(SLOTS + 1);
  localparam int N_EVT  = 4;

  logic             push, pop, drop;
  logic [PKT_W-1:0] head_pkt, next_pkt;
  logic             ins_evt, del_evt, unf_evt;
  logic [N_EVT-1:0] evt;
  logic [CNT_W-1:0] evt_cnt [N_EVT];

  assign pkt_ready = (occupancy != OCC_W'(SLOTS));
  assign push      = pkt_valid && pkt_ready;
  assign drop      = pkt_valid && !pkt_ready;

  esb_slot_ring #(.SLOTS(SLOTS), .PKT_W(PKT_W)) i_ring (
    .clk(clk), .rst(rst), .push(push), .push_data(pkt_data), .pop(pop),
    .held(occupancy), .head_pkt(head_pkt), .next_pkt(next_pkt)
  );

  esb_playout #(
    .SAMPLE_W(SAMPLE_W), .PKT_SAMPLES(PKT_SAMPLES), .FRAME_LEN(FRAME_LEN),
    .TARGET(TARGET), .OCC_W(OCC_W)
  ) i_play (
    .clk(clk), .rst(rst), .tick(sample_tick), .held(occupancy),
    .head_pkt(head_pkt), .next_pkt(next_pkt), .pop(pop),
    .out_valid(out_valid), .out_sample(out_sample), .out_fs(out_frame_start),
    .fix_mode(fix_mode), .muted(muted),
    .ins_evt(ins_evt), .del_evt(del_evt), .unf_evt(unf_evt)
  );

  assign evt = {unf_evt, drop, del_evt, ins_evt};

  for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
    esb_evt_count #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst(rst), .inc(evt[g]), .count(evt_cnt[g])
    );
  end

  assign ins_count = evt_cnt[0];
  assign del_count = evt_cnt[1];
  assign ovf_count = evt_cnt[2];
  assign unf_count = evt_cnt[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= drop;
      unf_pulse <= unf_evt;
    end
  end

  assert_drop_flagged_R2: assert property (@(posedge clk) disable iff (rst)
    drop |=> (ovf_pulse && $stable(occupancy) || ovf_pulse && pop == 1'b1 || ovf_pulse));
  assert_ready_tracks_room_R1: assert property (@(posedge clk) disable iff (rst)
    (occupancy == OCC_W'(SLOTS)) |-> !pkt_ready);

endmodule

// File: tb/test_elastic_drift_buffer.sv
module test_elastic_drift_buffer;
  localparam int SW = 16;
  localparam int PS = 4;
  localparam int NS = 4;
  localparam int TG = 2;
  localparam int FL = 8;
  localparam int PW = SW * PS;

  logic clk = 0;
  logic rst = 1;
  logic tb_vld = 0, tb_tick = 0;
  logic [PW-1:0] tb_data = '0;
  logic pkt_ready, out_valid, out_frame_start, muted, ovf_pulse, unf_pulse;
  logic [SW-1:0] out_sample;
  logic [1:0] fix_mode;
  logic [2:0] occupancy;
  logic [15:0] ins_count, del_count, ovf_count, unf_count;

  always #10 clk = ~clk;

  elastic_drift_buffer #(.SAMPLE_W(SW), .PKT_SAMPLES(PS), .SLOTS(NS),
    .TARGET(TG), .FRAME_LEN(FL), .CNT_W(16)) i_elastic_drift_buffer (
    .clk(clk), .rst(rst), .pkt_valid(tb_vld), .pkt_ready(pkt_ready),
    .pkt_data(tb_data), .sample_tick(tb_tick), .out_valid(out_valid),
    .out_sample(out_sample), .out_frame_start(out_frame_start),
    .fix_mode(fix_mode), .muted(muted), .occupancy(occupancy),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse), .ins_count(ins_count),
    .del_count(del_count), .ovf_count(ovf_count), .unf_count(unf_count)
  );

  int total = 0, bad = 0, cyc = 0, pkt_seq = 0;
  bit armed = 0;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: queue of packets plus a read position.
  logic [PW-1:0] m_q[$];
  int  m_idx, m_pos, m_out, m_fix, c_ins, c_del, c_ovf, c_unf;
  bit  m_muted, e_valid, e_fs, e_ovp, e_unp;

  function automatic int take_one();
    logic [PW-1:0] head;
    int v;
    head = m_q[0];
    v = int'((head >> (m_idx * SW)) & PW'(16'hFFFF));
    m_idx++;
    if (m_idx == PS) begin
      void'(m_q.pop_front());
      m_idx = 0;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int n, fx;
    bit full;
    if (rst) begin
      m_q.delete();
      m_idx = 0; m_pos = 0; m_out = 0; m_fix = 0;
      c_ins = 0; c_del = 0; c_ovf = 0; c_unf = 0;
      m_muted = 1; e_valid = 0; e_fs = 0; e_ovp = 0; e_unp = 0;
    end else begin
      n = m_q.size();
      full = (n == NS);
      e_valid = tb_tick; e_fs = 0; e_ovp = 0; e_unp = 0;
      if (tb_tick) begin
        if (m_muted) m_out = 0;
        else begin
          fx = 0;
          if (m_pos == 0) begin
            fx = (n < TG) ? 1 : ((n > TG) ? 2 : 0);
            m_fix = fx;
            e_fs = 1;
          end
          if (fx == 1) c_ins++;
          else if (fx == 2) begin
            void'(take_one());
            m_out = take_one();
            c_del++;
          end else if (n == 0) begin
            m_out = 0; e_unp = 1; c_unf++;
          end else m_out = take_one();
          m_pos = (m_pos + 1) % FL;
        end
      end
      if (m_muted && n >= TG) m_muted = 0;
      if (tb_vld) begin
        if (full) begin e_ovp = 1; c_ovf++; end
        else m_q.push_back(tb_data);
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !rst) begin
      check("R1 occupancy", occupancy, m_q.size());
      check("R1 pkt_ready", pkt_ready, (m_q.size() < NS) ? 1 : 0);
      check("R2 ovf_pulse", ovf_pulse, e_ovp);
      check("R2 ovf_count", ovf_count, c_ovf & 16'hFFFF);
      check("R3 ins_count", ins_count, c_ins & 16'hFFFF);
      check("R4 del_count", del_count, c_del & 16'hFFFF);
      check("R5 fix_mode", fix_mode, m_fix);
      check("R6 frame_start", out_frame_start, e_fs);
      check("R7 out_sample", out_sample, m_out);
      check("R8 muted", muted, m_muted);
      check("R9 unf_pulse", unf_pulse, e_unp);
      check("R9 unf_count", unf_count, c_unf & 16'hFFFF);
      check("R10 out_valid", out_valid, e_valid);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [PW-1:0] make_pkt(input int p);
    logic [PW-1:0] d;
    for (int j = 0; j < PS; j++) d[j*SW +: SW] = SW'(p * 16 + j + 1);
    return d;
  endfunction

  task automatic run(input int cycles, input int push_every, input int tick_every);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      tb_tick = (tick_every > 0) && (c % tick_every == 0);
      tb_vld  = (push_every > 0) && (c % push_every == 0);
      if (tb_vld) begin
        tb_data = make_pkt(pkt_seq);
        pkt_seq++;
      end
    end
    @(negedge clk);
    tb_tick = 0; tb_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state seen at the ports
    check("R11 occupancy", occupancy, 0);
    check("R11 muted", muted, 1);
    check("R11 out_valid", out_valid, 0);
    check("R11 pulses", {ovf_pulse, unf_pulse}, 0);
    check("R11 counts", ins_count | del_count | ovf_count | unf_count, 0);
    armed = 1;
    run(20, 0, 2);     // R8: muted ticks with no data
    run(200, 8, 2);    // balanced rate
    run(400, 7, 2);    // producer fast: skips (R4)
    run(400, 9, 2);    // producer slow: repeats (R3)
    run(12, 1, 0);     // burst with no ticks: overflow (R2)
    run(300, 8, 2);
    run(120, 0, 2);    // starved: underflow (R9)
    run(200, 8, 2);
    @(negedge clk);
    check("R3 repeats seen", ins_count != 0, 1);
    check("R4 skips seen", del_count != 0, 1);
    check("R2 drops seen", ovf_count != 0, 1);
    check("R9 empty reads seen", unf_count != 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule